// File: doc/BRIEF.md
# Linked-Descriptor Transmit DMA

This engine moves outgoing packets from memory to a byte-stream consumer by following a chain of three-word descriptors. Each descriptor records where the packet buffer starts, a control word that holds an "empty" ownership flag and the packet length, and the address of the next descriptor. Software loads the address of the first descriptor and then sets the run bit. From then on the engine fetches descriptors and sends packets on its own.

For each descriptor that software has filled, the engine reads the buffer one 32-bit word at a time. It presents the bytes on a valid/ready stream and flags the final byte. It then gives the descriptor back by writing its control word with the empty flag set, and moves on to the next descriptor. The engine stops when it meets a descriptor that is still marked empty. Software can also stop it by clearing the run bit. In that case the packet already in flight finishes first, and software polls the control register until it reads zero.

Top module: `txring_dma`

## Requirements
- R1: After reset, `tx_valid` and `mem_req` are low, the control register (csr_addr 0) reads 0 and the pointer register (csr_addr 1) reads 0.
- R2: A descriptor at address P holds the buffer address at P, the control word at P+4 and the next-descriptor address at P+8. In the control word, bit 31 is the empty flag and bits 11:0 are the length in bytes.
- R3: For a descriptor whose empty flag is clear and whose length is N > 0, the engine emits exactly N bytes, in rising address order, starting at the buffer address. `tx_last` is high on the N-th byte only.
- R4: Byte lanes are little-endian: the byte at address A is bits 8*(A mod 4)+7 down to 8*(A mod 4) of the word at A with its two low bits cleared. A buffer may start at any byte address.
- R5: After its data phase, the engine writes word P+4 with the fetched control word OR 0x8000_0000. It then loads the next-descriptor address into the pointer register and, while the run bit is set, fetches that descriptor.
- R6: When a fetched control word has bit 31 set, the engine writes nothing and emits nothing. It clears the run bit and goes idle, and the control register reads 0.
- R7: A length of 0 sends no bytes, but the write-back and the pointer advance still happen.
- R8: Writing 0 to the control register lets the current packet finish, including its write-back and pointer advance. The control register reads 1 until the engine is idle and 0 afterwards, and no further descriptor is fetched.
- R9: Writes to the pointer register are ignored while the control register reads 1.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R11: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 1 | Register select: 0 control, 1 descriptor pointer |
| csr_wdata | input | 32 | Register write data (control uses bit 0) |
| csr_rdata | output | 32 | Register read data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the request this cycle; read data valid |
| mem_rdata | input | 32 | Memory read data |
| tx_data | output | 8 | Stream byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_last | output | 1 | Final byte of the packet |
| tx_ready | input | 1 | Stream consumer accepts the byte |

## Verification
The bench builds the engine with its default 32-bit address and 12-bit length field, and backs it with a 1 KiB memory. Under those settings a single chain can mix an aligned buffer, an unaligned buffer whose bytes cross word boundaries, a zero-length descriptor and a terminating empty descriptor. A 20-byte packet then leaves enough time to clear the run bit in mid-packet. Memory and stream stalls follow fixed periodic patterns, so every request hold and every byte hold is exercised across the scenarios.

// File: rtl/txring_dma.sv
module txring_dma #(
  parameter int AW    = 32,
  parameter int LEN_W = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csr_we,
  input  logic          csr_addr,
  input  logic [31:0]   csr_wdata,
  output logic [31:0]   csr_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ready,
  input  logic [31:0]   mem_rdata,
  output logic [7:0]    tx_data,
  output logic          tx_valid,
  output logic          tx_last,
  input  logic          tx_ready
);
  localparam logic [31:0] EMPTY_MASK = 32'h8000_0000;
  localparam logic [AW-1:0] OFS_CFG = AW'(4);
  localparam logic [AW-1:0] OFS_NXT = AW'(8);

  typedef enum logic [2:0] {S_IDLE, S_CFG, S_NXT, S_BUF, S_WORD, S_BYTE, S_WB} st_t;
  st_t state;

  logic            run;
  logic [AW-1:0]   ptr, nxt, baddr;
  logic [31:0]     cfg, word;
  logic [LEN_W-1:0] remain;

  wire busy = run || (state != S_IDLE);
  wire ack  = mem_req && mem_ready;
  wire hs   = tx_valid && tx_ready;

  assign csr_rdata = csr_addr ? 32'(ptr) : {31'b0, busy};
  assign tx_valid  = (state == S_BYTE);
  assign tx_data   = word[{baddr[1:0], 3'b000} +: 8];
  assign tx_last   = tx_valid && (remain == LEN_W'(1));

  always_comb begin
    mem_req   = 1'b1;
    mem_we    = 1'b0;
    mem_addr  = ptr;
    mem_wdata = '0;
    case (state)
      S_CFG:  mem_addr = ptr + OFS_CFG;
      S_NXT:  mem_addr = ptr + OFS_NXT;
      S_BUF:  mem_addr = ptr;
      S_WORD: mem_addr = {baddr[AW-1:2], 2'b00};
      S_WB: begin
        mem_we    = 1'b1;
        mem_addr  = ptr + OFS_CFG;
        mem_wdata = cfg | EMPTY_MASK;
      end
      default: mem_req = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      run    <= 1'b0;
      ptr    <= '0;
      nxt    <= '0;
      baddr  <= '0;
      cfg    <= '0;
      word   <= '0;
      remain <= '0;
    end else begin
      case (state)
        S_IDLE: if (run) state <= S_CFG;
        S_CFG: if (ack) begin
          cfg <= mem_rdata;
          if (mem_rdata[31]) begin
            run   <= 1'b0;
            state <= S_IDLE;
          end else begin
            state <= S_NXT;
          end
        end
        S_NXT: if (ack) begin
          nxt   <= mem_rdata[AW-1:0];
          state <= (cfg[LEN_W-1:0] == '0) ? S_WB : S_BUF;
        end
        S_BUF: if (ack) begin
          baddr  <= mem_rdata[AW-1:0];
          remain <= cfg[LEN_W-1:0];
          state  <= S_WORD;
        end
        S_WORD: if (ack) begin
          word  <= mem_rdata;
          state <= S_BYTE;
        end
        S_BYTE: if (hs) begin
          baddr  <= baddr + AW'(1);
          remain <= remain - LEN_W'(1);
          if (remain == LEN_W'(1))   state <= S_WB;
          else if (baddr[1:0] == 2'b11) state <= S_WORD;
        end
        S_WB: if (ack) begin
          ptr   <= nxt;
          state <= run ? S_CFG : S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
      if (csr_we && !csr_addr) run <= csr_wdata[0];
      if (csr_we && csr_addr && !busy) ptr <= csr_wdata[AW-1:0];
    end
  end
endmodule

// File: rtl/txring_dma_chk.sv
module txring_dma_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          mem_ready,
  input logic [7:0]    tx_data,
  input logic          tx_valid,
  input logic          tx_last,
  input logic          tx_ready
);
  assert_tx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

  assert_wb_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[31]);

  assert_one_side_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && mem_req));

  assert_last_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);
endmodule

bind txring_dma txring_dma_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
  .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready)
);

// File: tb/txring_dma_tb.sv
module txring_dma_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic        csr_addr = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        mem_req, mem_we, mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_last, tx_ready = 1'b0;

  int checks = 0, errors = 0, cyc = 0, nbytes = 0;
  logic [31:0] mem [0:255];
  logic [8:0]  exp_b[$];
  logic [63:0] exp_w[$];

  always #5 clk = ~clk;

  txring_dma dut_i (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready)
  );

  assign mem_rdata = mem[mem_addr[9:2]];

  function automatic logic [7:0] byte_at(int a);
    return 8'(a * 7 + 3);
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    #1;
    cyc++;
    tx_ready  = (cyc % 3) != 1;
    mem_ready = (cyc % 5) != 2;
    if (cyc > 50000) begin
      check(0, "watchdog", cyc, 50000);
      summary();
    end
  end

  // reference comparison every cycle: stream bytes and write-backs
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      nbytes++;
      if (exp_b.size() == 0) check(0, "R3 unexpected byte", {tx_last, tx_data}, 0);
      else begin
        logic [8:0] e;
        e = exp_b.pop_front();
        check({tx_last, tx_data} == e, "R3 R4 byte/last", {tx_last, tx_data}, e);
      end
    end
    if (rst_n && mem_req && mem_ready && mem_we) begin
      if (exp_w.size() == 0) check(0, "R5 unexpected write", {mem_addr, mem_wdata}, 0);
      else begin
        logic [63:0] e;
        e = exp_w.pop_front();
        check({mem_addr, mem_wdata} == e, "R5 R7 write-back", {mem_addr, mem_wdata}, e);
      end
      mem[mem_addr[9:2]] = mem_wdata;
    end
  end

  task automatic csr_wr(logic a, logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic csr_rd(logic a, output logic [31:0] d);
    @(negedge clk);
    csr_addr = a;
    #1 d = csr_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    v = 1;
    while (v != 0) csr_rd(1'b0, v);
  endtask

  task automatic set_desc(int p, int b, logic [31:0] c, int n);
    mem[p/4] = 32'(b); mem[p/4+1] = c; mem[p/4+2] = 32'(n);
  endtask

  task automatic push_pkt(int b, int n);
    for (int k = 0; k < n; k++) exp_b.push_back({k == n - 1, byte_at(b + k)});
  endtask

  initial begin
    logic [31:0] v;
    for (int w = 0; w < 256; w++)
      mem[w] = {byte_at(4*w+3), byte_at(4*w+2), byte_at(4*w+1), byte_at(4*w)};
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    check(!tx_valid && !mem_req, "R1 idle outputs", {tx_valid, mem_req}, 0);
    csr_rd(1'b0, v); check(v == 0, "R1 control", v, 0);
    csr_rd(1'b1, v); check(v == 0, "R1 pointer", v, 0);

    // Scenario 1: aligned, unaligned, zero length, then empty (R2..R7, R9)
    set_desc('h100, 'h200, 32'd5, 'h110);
    set_desc('h110, 'h243, 32'd7, 'h120);
    set_desc('h120, 'h2F0, 32'd0, 'h130);
    set_desc('h130, 'h300, 32'h8000_0004, 'h140);
    push_pkt('h200, 5);
    push_pkt('h243, 7);
    exp_w.push_back({32'h104, 32'h8000_0005});
    exp_w.push_back({32'h114, 32'h8000_0007});
    exp_w.push_back({32'h124, 32'h8000_0000});
    csr_wr(1'b1, 32'h100);
    csr_rd(1'b1, v); check(v == 32'h100, "R2 pointer load", v, 32'h100);
    csr_wr(1'b0, 32'h1);
    csr_rd(1'b0, v); check(v == 1, "R8 busy readback", v, 1);
    csr_wr(1'b1, 32'h1F0);   // R9: must be ignored
    wait_idle();
    check(exp_b.size() == 0, "R3 all bytes sent", exp_b.size(), 0);
    check(nbytes == 12, "R7 zero-length sends none", nbytes, 12);
    check(exp_w.size() == 0, "R5 all write-backs", exp_w.size(), 0);
    check(mem['h134/4] == 32'h8000_0004, "R6 empty untouched", mem['h134/4], 32'h8000_0004);
    csr_rd(1'b1, v); check(v == 32'h130, "R9 pointer ignored, R5 advance", v, 32'h130);
    csr_rd(1'b0, v); check(v == 0, "R6 run cleared", v, 0);
    repeat (10) @(negedge clk);
    check(!tx_valid && !mem_req, "R6 stays idle", {tx_valid, mem_req}, 0);

    // Scenario 2: stop request during a packet (R8)
    nbytes = 0;
    set_desc('h140, 'h280, 32'd20, 'h150);
    set_desc('h150, 'h2C0, 32'd4, 'h160);
    push_pkt('h280, 20);
    exp_w.push_back({32'h144, 32'h8000_0014});
    csr_wr(1'b1, 32'h140);
    csr_wr(1'b0, 32'h1);
    while (nbytes == 0) @(negedge clk);
    csr_wr(1'b0, 32'h0);
    csr_rd(1'b0, v); check(v == 1, "R8 reads 1 until idle", v, 1);
    wait_idle();
    check(nbytes == 20, "R8 packet completes", nbytes, 20);
    check(exp_w.size() == 0, "R8 write-back done", exp_w.size(), 0);
    check(mem['h154/4] == 32'd4, "R8 next not consumed", mem['h154/4], 4);
    csr_rd(1'b1, v); check(v == 32'h150, "R8 pointer advanced", v, 32'h150);
    repeat (10) @(negedge clk);
    check(!tx_valid && !mem_req, "R8 no further fetch", {tx_valid, mem_req}, 0);

    summary();
  end
endmodule